// File: doc/BRIEF.md
# Posted Write Buffer with Line-End Counter

This block collects write data that a bus master sends toward memory. The data goes into a small set of posting buffers, so the master does not have to wait for the memory side. An external sequencer controls the block through a two-bit command code. A bus-sampling register holds the bus value from the previous cycle. An address-capture command moves that sampled value into a master address latch. A select command moves to the next buffer and gives it that address. A post command appends the sampled data word to the selected buffer.

A single counter is shared by all buffers. It tracks how many 32-bit words are left before the current cache line ends, and it decrements on every select and post command. On address capture it also raises an end-of-line flag when the addressed word is the last word of its line. The sequencer uses this flag to decide when to stop a burst. Draining the buffers toward memory happens outside the block, through the combinational read port and the per-buffer address and count outputs.

Top module: `post_wbuf_top`

## Requirements
- R1: While synchronous reset is high, the block goes to its reset state on each clock edge. In that state every buffer count is 0, the words-left count is 0, the end-of-line flag is 0, the master address is 0, and the selected buffer index is NBUF-1.
- R2: On every clock edge the bus-sampling register takes the value of `bus_in`. The capture command (code 2'b01) copies the sampled value, which is the bus value of the previous cycle, into the master address latch.
- R3: The select command (code 2'b10) moves the selected index to the next buffer, wrapping from NBUF-1 to 0, so the first select after reset picks buffer 0. It loads the master address into that buffer's address register and clears its count to 0. The other buffers are left untouched.
- R4: The post command (code 2'b11) writes the sampled data word into the slot of the selected buffer whose index equals that buffer's count. It then increments the count. The first post after a select therefore fills slot 0.
- R5: A post command given while the selected buffer already holds DEPTH words changes neither the buffer's slots nor its count.
- R6: Each select and each post command decrements the words-left count by one. The count stays at 0 if it is already 0.
- R7: On capture, the words-left count becomes 8 minus address bits [4:2], and the end-of-line flag is set exactly when bits [4:2] equal 7. No other command changes the end-of-line flag.
- R8: The no-operation command (code 2'b00) leaves the selected index, the counts, the addresses, the words-left count and the end-of-line flag unchanged.
- R9: `rd_data` shows, without a clock delay, the slot `rd_slot` of buffer `rd_buf`. Buffer b's address is at `buf_addr[b*32 +: 32]` and its count is at `buf_cnt[b*4 +: 4]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 2 | Command: 00 no-op, 01 capture, 10 select, 11 post |
| bus_in | input | 32 | Bus value, sampled every cycle |
| rd_buf | input | 1 | Buffer index for the read port |
| rd_slot | input | 3 | Slot index for the read port |
| rd_data | output | 32 | Contents of the addressed slot |
| cur_buf | output | 1 | Index of the currently selected buffer |
| buf_addr | output | 64 | Address register of each buffer, packed |
| buf_cnt | output | 8 | Valid-word count of each buffer, packed |
| words_left | output | 4 | Words remaining before the line boundary |
| eol | output | 1 | Addressed word is the last word of its line |

## Verification
The bench checks that the capture command takes the bus value from the previous cycle. A design that latched the same-cycle bus value would load the wrong address and the wrong words-left count. It also checks that the words-left count stays at zero when a burst runs past the line end, instead of wrapping to 15. It fills a buffer completely and then posts once more. A design without the full check would overwrite slot 0 or let the count grow to 9. Finally, it checks that selecting a buffer clears only that buffer's count, and that the end-of-line flag stays set through later select and post commands.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'b00,
        CMD_ACAP = 2'b01,
        CMD_SEL  = 2'b10,
        CMD_POST = 2'b11
    } pwb_cmd_e;

    localparam int unsigned PWB_LINE_BYTES = 32;
    localparam int unsigned PWB_WORD_BYTES = 4;

endpackage

// File: rtl/pwb_addr_latch.sv
module pwb_addr_latch #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] bus_in,
    input  logic         is_acap,
    output logic [W-1:0] ad_lat,
    output logic [W-1:0] maddr
);

    typedef struct packed {
        logic [W-1:0] ad;
        logic [W-1:0] ma;
    } lat_t;

    lat_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.ad = bus_in;
        if (is_acap) begin
            s_d.ma = s_q.ad;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ad_lat = s_q.ad;
    assign maddr  = s_q.ma;

    // R2: capture moves last cycle's sampled bus value into the address latch
    a_r2_capture_prev_bus: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(is_acap)) |-> (maddr == $past(ad_lat)));

    // R2: without capture the address latch holds
    a_r2_maddr_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(is_acap)) |-> $stable(maddr));

endmodule

// File: rtl/pwb_eol_ctr.sv
module pwb_eol_ctr #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             is_acap,
    input  logic             is_step,
    input  logic [IDX_W-1:0] cap_idx,
    output logic [CNT_W-1:0] words_left,
    output logic             eol
);

    typedef struct packed {
        logic [CNT_W-1:0] left;
        logic             eol;
    } ctr_t;

    ctr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (is_acap) begin
            s_d.left = CNT_W'(DEPTH) - CNT_W'(cap_idx);
            s_d.eol  = (cap_idx == IDX_W'(DEPTH - 1));
        end else if (is_step) begin
            if (s_q.left != '0) begin
                s_d.left = s_q.left - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign words_left = s_q.left;
    assign eol        = s_q.eol;

    // R6: a step from a non-zero count lowers it by exactly one
    a_r6_step_decrements: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(is_step) && $past(words_left) != '0)
            |-> (words_left == $past(words_left) - CNT_W'(1)));

    // R6: a step at zero keeps zero
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(is_step) && $past(words_left) == '0)
            |-> (words_left == '0));

    // R7: the flag moves only on capture
    a_r7_eol_only_on_capture: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(is_acap)) |-> $stable(eol));

    // R7: the count never exceeds a full line
    a_r7_left_in_range: assert property (@(posedge clk) disable iff (rst)
        words_left <= CNT_W'(DEPTH));

endmodule

// File: rtl/pwb_buf_bank.sv
module pwb_buf_bank #(
    parameter int unsigned NBUF  = 2,
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 32,
    localparam int unsigned BUF_W = (NBUF > 1) ? $clog2(NBUF) : 1,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  is_sel,
    input  logic                  is_post,
    input  logic [W-1:0]          maddr,
    input  logic [W-1:0]          wdata,
    input  logic [BUF_W-1:0]      rd_buf,
    input  logic [IDX_W-1:0]      rd_slot,
    output logic [W-1:0]          rd_data,
    output logic [BUF_W-1:0]      cur_buf,
    output logic [NBUF*W-1:0]     buf_addr,
    output logic [NBUF*CNT_W-1:0] buf_cnt
);

    typedef struct packed {
        logic [BUF_W-1:0]                  cur;
        logic [NBUF-1:0][W-1:0]            addr;
        logic [NBUF-1:0][CNT_W-1:0]        cnt;
        logic [NBUF-1:0][DEPTH-1:0][W-1:0] mem;
    } bank_t;

    bank_t s_d, s_q;

    logic [BUF_W-1:0] nxt_buf;
    logic [CNT_W-1:0] cur_cnt;
    logic             cur_full;

    always_comb begin
        if (s_q.cur == BUF_W'(NBUF - 1)) begin
            nxt_buf = '0;
        end else begin
            nxt_buf = s_q.cur + BUF_W'(1);
        end
    end

    assign cur_cnt  = s_q.cnt[s_q.cur];
    assign cur_full = (cur_cnt >= CNT_W'(DEPTH));

    always_comb begin
        s_d = s_q;
        if (is_sel) begin
            s_d.cur           = nxt_buf;
            s_d.addr[nxt_buf] = maddr;
            s_d.cnt[nxt_buf]  = '0;
        end else if (is_post && !cur_full) begin
            s_d.mem[s_q.cur][cur_cnt[IDX_W-1:0]] = wdata;
            s_d.cnt[s_q.cur] = cur_cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q     <= '0;
            s_q.cur <= BUF_W'(NBUF - 1);
        end else begin
            s_q <= s_d;
        end
    end

    generate
        if (NBUF == (1 << BUF_W)) begin : g_rd_full
            assign rd_data = s_q.mem[rd_buf][rd_slot];
        end else begin : g_rd_guard
            assign rd_data = (rd_buf < BUF_W'(NBUF)) ? s_q.mem[rd_buf][rd_slot] : '0;
        end
    endgenerate

    assign cur_buf  = s_q.cur;
    assign buf_addr = s_q.addr;
    assign buf_cnt  = s_q.cnt;

    // R3: select lands on a different buffer and empties it
    a_r3_sel_empties: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(is_sel))
            |-> (cur_cnt == '0 && cur_buf != $past(cur_buf)));

    // R4: a post into a non-full buffer grows its count by one
    a_r4_post_grows: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(is_post) && $past(cur_cnt) < CNT_W'(DEPTH))
            |-> (cur_cnt == $past(cur_cnt) + CNT_W'(1)));

    // R5: a post into a full buffer leaves it full
    a_r5_full_holds: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(is_post) && $past(cur_cnt) == CNT_W'(DEPTH))
            |-> $stable(buf_cnt));

    // R5: no count ever passes the buffer depth
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cur_cnt <= CNT_W'(DEPTH));

endmodule

// File: rtl/post_wbuf_top.sv
module post_wbuf_top #(
    parameter int unsigned NBUF  = 2,
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 32,
    localparam int unsigned BUF_W = (NBUF > 1) ? $clog2(NBUF) : 1,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned LSB   = $clog2(pwb_pkg::PWB_WORD_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            cmd,
    input  logic [W-1:0]          bus_in,
    input  logic [BUF_W-1:0]      rd_buf,
    input  logic [IDX_W-1:0]      rd_slot,
    output logic [W-1:0]          rd_data,
    output logic [BUF_W-1:0]      cur_buf,
    output logic [NBUF*W-1:0]     buf_addr,
    output logic [NBUF*CNT_W-1:0] buf_cnt,
    output logic [CNT_W-1:0]      words_left,
    output logic                  eol
);

    import pwb_pkg::*;

    pwb_cmd_e   cmd_e;
    logic       is_acap, is_sel, is_post, is_step;
    logic [W-1:0] ad_lat, maddr;

    assign cmd_e   = pwb_cmd_e'(cmd);
    assign is_acap = (cmd_e == CMD_ACAP);
    assign is_sel  = (cmd_e == CMD_SEL);
    assign is_post = (cmd_e == CMD_POST);
    assign is_step = is_sel || is_post;

    pwb_addr_latch #(.W(W)) u_lat (
        .clk     (clk),
        .rst     (rst),
        .bus_in  (bus_in),
        .is_acap (is_acap),
        .ad_lat  (ad_lat),
        .maddr   (maddr)
    );

    pwb_eol_ctr #(.DEPTH(DEPTH)) u_eol (
        .clk        (clk),
        .rst        (rst),
        .is_acap    (is_acap),
        .is_step    (is_step),
        .cap_idx    (ad_lat[LSB +: IDX_W]),
        .words_left (words_left),
        .eol        (eol)
    );

    pwb_buf_bank #(.NBUF(NBUF), .DEPTH(DEPTH), .W(W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .is_sel   (is_sel),
        .is_post  (is_post),
        .maddr    (maddr),
        .wdata    (ad_lat),
        .rd_buf   (rd_buf),
        .rd_slot  (rd_slot),
        .rd_data  (rd_data),
        .cur_buf  (cur_buf),
        .buf_addr (buf_addr),
        .buf_cnt  (buf_cnt)
    );

    // R8: a no-op cycle changes no visible state
    a_r8_nop_idle: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cmd) == 2'b00)
            |-> ($stable(cur_buf) && $stable(buf_cnt) && $stable(buf_addr)
                 && $stable(words_left) && $stable(eol)));

    // R1: the cycle after reset shows the reset state
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (buf_cnt == '0 && words_left == '0 && !eol
                        && cur_buf == BUF_W'(NBUF - 1)));

endmodule

// File: tb/post_wbuf_top_tb_top.sv
`timescale 1ns/1ps
module post_wbuf_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cmd = 2'b00;
    logic [31:0] bus_in = '0;
    logic [0:0]  rd_buf = '0;
    logic [2:0]  rd_slot = '0;
    logic [31:0] rd_data;
    logic [0:0]  cur_buf;
    logic [63:0] buf_addr;
    logic [7:0]  buf_cnt;
    logic [3:0]  words_left;
    logic        eol;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    post_wbuf_top dut_i (
        .clk(clk), .rst(rst), .cmd(cmd), .bus_in(bus_in),
        .rd_buf(rd_buf), .rd_slot(rd_slot), .rd_data(rd_data),
        .cur_buf(cur_buf), .buf_addr(buf_addr), .buf_cnt(buf_cnt),
        .words_left(words_left), .eol(eol)
    );

    localparam logic [1:0] NOP = 2'b00, CAP = 2'b01, SEL = 2'b10, PST = 2'b11;

    // fields: cmd, bus, expected words_left, eol, cur_buf, count of current buffer
    localparam int NV = 11;
    localparam logic [43:0] VEC [NV] = '{
        {NOP, 32'h1000_0014, 4'd0, 1'b0, 1'b1, 4'd0},
        {CAP, 32'h0000_00A0, 4'd3, 1'b0, 1'b1, 4'd0},
        {SEL, 32'h0000_00A1, 4'd2, 1'b0, 1'b0, 4'd0},
        {PST, 32'h0000_00A2, 4'd1, 1'b0, 1'b0, 4'd1},
        {PST, 32'h0000_00A3, 4'd0, 1'b0, 1'b0, 4'd2},
        {PST, 32'h2000_001C, 4'd0, 1'b0, 1'b0, 4'd3},
        {CAP, 32'h0000_00B0, 4'd1, 1'b1, 1'b0, 4'd3},
        {SEL, 32'h0000_00B1, 4'd0, 1'b1, 1'b1, 4'd0},
        {PST, 32'h3000_0000, 4'd0, 1'b1, 1'b1, 4'd1},
        {CAP, 32'h0000_0000, 4'd8, 1'b0, 1'b1, 4'd1},
        {NOP, 32'h0000_0000, 4'd8, 1'b0, 1'b1, 4'd1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] c, input logic [31:0] b);
        @(negedge clk);
        cmd    = c;
        bus_in = b;
        @(posedge clk);
        #1;
    endtask

    task automatic peek(input int b, input int s, output logic [31:0] v);
        rd_buf  = 1'(b);
        rd_slot = 3'(s);
        #0.1;
        v = rd_data;
    endtask

    function automatic logic [3:0] cnt_of(input int b);
        return buf_cnt[b*4 +: 4];
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 cur", 32'(cur_buf), 32'd1);
        chk("R1 cnt", 32'(buf_cnt), 32'd0);
        chk("R1 left", 32'(words_left), 32'd0);
        chk("R1 eol", 32'(eol), 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // R2 R3 R4 R6 R7 R8 vector walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][43:42], VEC[i][41:10]);
            chk($sformatf("R6 R7 left v%0d", i), 32'(words_left), 32'(VEC[i][9:6]));
            chk($sformatf("R7 eol v%0d", i), 32'(eol), 32'(VEC[i][5]));
            chk($sformatf("R3 cur v%0d", i), 32'(cur_buf), 32'(VEC[i][4]));
            chk($sformatf("R4 R8 cnt v%0d", i), 32'(cnt_of(int'(cur_buf))), 32'(VEC[i][3:0]));
        end
        // R2 R3 captured addresses reached the buffers
        chk("R2 R3 addr0", buf_addr[31:0], 32'h1000_0014);
        chk("R2 R3 addr1", buf_addr[63:32], 32'h2000_001C);
        // R4 R9 slot contents
        peek(0, 0, v); chk("R4 R9 b0s0", v, 32'hA1);
        peek(0, 1, v); chk("R4 R9 b0s1", v, 32'hA2);
        peek(0, 2, v); chk("R4 R9 b0s2", v, 32'hA3);
        peek(1, 0, v); chk("R4 R9 b1s0", v, 32'hB1);
        chk("R3 other count kept", 32'(cnt_of(0)), 32'd3);

        // R5 fill buffer 0 then post once more
        step(SEL, 32'hC000_0000);
        chk("R3 wrap to 0", 32'(cur_buf), 32'd0);
        chk("R3 cleared", 32'(cnt_of(0)), 32'd0);
        for (int k = 1; k <= 9; k++) begin
            step(PST, 32'hC000_0000 + 32'(k));
        end
        chk("R5 count held at 8", 32'(cnt_of(0)), 32'd8);
        peek(0, 0, v); chk("R5 slot0 kept", v, 32'hC000_0000);
        peek(0, 7, v); chk("R5 slot7", v, 32'hC000_0007);
        chk("R6 saturated", 32'(words_left), 32'd0);
        chk("R8 addr1 untouched", buf_addr[63:32], 32'h2000_001C);

        // R3 select buffer 1 leaves buffer 0 intact
        step(SEL, 32'h0);
        chk("R3 sel b1", 32'(cur_buf), 32'd1);
        chk("R3 b1 empty", 32'(cnt_of(1)), 32'd0);
        chk("R3 b0 full kept", 32'(cnt_of(0)), 32'd8);

        // R7 capture at word index 6
        step(NOP, 32'h4000_0018);
        step(CAP, 32'h0);
        chk("R7 left idx6", 32'(words_left), 32'd2);
        chk("R7 eol idx6", 32'(eol), 32'd0);

        // R1 reset mid run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 mid cnt", 32'(buf_cnt), 32'd0);
        chk("R1 mid cur", 32'(cur_buf), 32'd1);
        chk("R1 mid left", 32'(words_left), 32'd0);
        @(negedge clk);
        rst = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule